// File: doc/BRIEF.md
# Sector Program Controller

This block sits in front of a byte-wide memory that is rewritten one whole sector at a time. Byte writes on a synchronous bus are gathered into a sector-sized staging buffer. The bytes may arrive in any order. The gathering phase stays open while writes keep arriving. Once a quiet interval passes with no accepted write, the controller becomes busy and runs a timed internal cycle. That cycle erases the target sector and then fills it from the buffer.

The array inside is a behavioural store. It holds only `2**STORE_SECT_W` sectors, and higher sector numbers alias onto them by their low bits. While the internal cycle runs, reads do not return array contents. They return a status byte instead, so the host can follow progress in either of two ways: watch bit 7, which carries the inverted bit 7 of the last loaded byte, or watch bit 6, which flips on every read. After the cycle the sector holds each loaded byte. Every byte that was not loaded reads as all-ones.

Top module: `sector_prog_ctrl`

## Requirements
- R1: A cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1 while idle or loading is a read. In the next cycle `dout` holds the byte at `addr`, where `addr[7:0]` is the byte within the sector and the low `STORE_SECT_W` bits of `addr[17:8]` pick the stored sector. In any cycle after a non-read cycle, `dout` is 8'h00.
- R2: A write is accepted only in a cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. An accepted write stores `din` at byte `addr[7:0]` of the buffer. Any other combination of strobes stores nothing and starts no cycle.
- R3: `busy` rises exactly `LOAD_WINDOW` cycles after the clock edge of the last accepted write. Each accepted write restarts this count.
- R4: `busy` stays high for `PROG_CYCLES` cycles. After it falls, the sector holds every loaded byte, and every byte not loaded in that load period reads 8'hFF.
- R5: A read while `busy` is high returns bit 7 equal to the inverse of bit 7 of the last loaded byte. Bits 5..0 of that read equal bits 5..0 of the last loaded byte.
- R6: Bit 6 of the status byte is 0 on the first read of a cycle and inverts on each further read. Once `busy` is low, reads return array data.
- R7: Writes while `busy` is high have no effect on the stored data or on the cycle timing.
- R8: During loading, a write whose `addr[17:8]` differs from the sector of the first write is ignored. It does not restart the window.
- R9: After reset, `busy` is 0, `dout` is 8'h00, and every byte of the array reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits select the sector |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while the internal erase/program cycle runs |

## Verification
The bench builds the block with `LOAD_WINDOW`=20, `PROG_CYCLES`=50 and `STORE_SECT_W`=2. At these values the window expiry and the cycle end fall within tens of cycles, so the bench can test the exact edge on which `busy` rises and falls. It can also restart the window one cycle before it would close. Using four stored sectors means that an access to sector 5 reaches sector 1, which exercises the aliasing. It also means that an ignored write to sector 2 can be seen to leave that sector blank.

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl #(
  parameter int ADDR_W       = 18,
  parameter int BYTE_W       = 8,
  parameter int STORE_SECT_W = 2,
  parameter int LOAD_WINDOW  = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy
);
  localparam int SECT_BYTES  = 1 << BYTE_W;
  localparam int STORE_SECTS = 1 << STORE_SECT_W;
  localparam int STORE_BYTES = 1 << (STORE_SECT_W + BYTE_W);
  localparam int SECT_W      = ADDR_W - BYTE_W;
  localparam int MAXC        = (LOAD_WINDOW > PROG_CYCLES) ? LOAD_WINDOW : PROG_CYCLES;
  localparam int CNT_W       = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(LOAD_WINDOW - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_BUSY} state_t;

  state_t                state;
  logic [CNT_W-1:0]      cnt;
  logic [SECT_W-1:0]     sec_q;
  logic [7:0]            last_q;
  logic                  tgl;
  logic [SECT_BYTES-1:0] loaded;
  logic [STORE_SECTS-1:0] sect_ok;
  logic [7:0]            sbuf [SECT_BYTES];
  logic [7:0]            mem  [STORE_BYTES];

  logic wr_stb, rd_stb, wr_acc, done;
  logic [STORE_SECT_W-1:0]        csel, rsel;
  logic [STORE_SECT_W+BYTE_W-1:0] ridx;
  logic [7:0] rd_data;

  assign wr_stb  = !ce_n && !we_n && oe_n;
  assign rd_stb  = !ce_n && !oe_n && we_n;
  assign wr_acc  = wr_stb && (state == S_IDLE ||
                   (state == S_LOAD && addr[ADDR_W-1:BYTE_W] == sec_q));
  assign done    = (state == S_BUSY) && (cnt == PROG_LAST);
  assign busy    = (state == S_BUSY);
  assign csel    = sec_q[STORE_SECT_W-1:0];
  assign rsel    = addr[BYTE_W+STORE_SECT_W-1:BYTE_W];
  assign ridx    = {rsel, addr[BYTE_W-1:0]};
  assign rd_data = sect_ok[rsel] ? mem[ridx] : 8'hFF;

  always_ff @(posedge clk) begin
    if (wr_acc) sbuf[addr[BYTE_W-1:0]] <= din;
    if (done)
      for (int i = 0; i < SECT_BYTES; i++)
        mem[{csel, i[BYTE_W-1:0]}] <= loaded[i] ? sbuf[i] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sec_q   <= '0;
      last_q  <= '0;
      tgl     <= 1'b0;
      loaded  <= '0;
      sect_ok <= '0;
      dout    <= '0;
    end else begin
      if (!rd_stb)      dout <= 8'h00;
      else if (busy)    dout <= {~last_q[7], tgl, last_q[5:0]};
      else              dout <= rd_data;

      if (wr_acc) begin
        last_q <= din;
        loaded[addr[BYTE_W-1:0]] <= 1'b1;
      end

      case (state)
        S_IDLE: if (wr_acc) begin
          state <= S_LOAD;
          cnt   <= '0;
          sec_q <= addr[ADDR_W-1:BYTE_W];
        end
        S_LOAD: begin
          if (wr_acc) cnt <= '0;
          else if (cnt == WIN_LAST) begin
            state <= S_BUSY;
            cnt   <= '0;
            tgl   <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (rd_stb) tgl <= ~tgl;
          if (done) begin
            state         <= S_IDLE;
            cnt           <= '0;
            loaded        <= '0;
            sect_ok[csel] <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  p_quiet_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wr_acc));

  p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> $stable(last_q));

  p_poll_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb) |=> (dout[7] == ~last_q[7]));

  p_toggle_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb && $past(busy && rd_stb)) |=> (dout[6] != $past(dout[6])));

  p_no_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (dout == 8'h00));
endmodule

// File: tb/test_sector_prog_ctrl.sv
module test_sector_prog_ctrl;
  localparam int AW = 18;
  localparam int W  = 20;
  localparam int P  = 50;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy;

  int checks = 0, failures = 0;
  bit finished = 0;

  sector_prog_ctrl #(.ADDR_W(AW), .BYTE_W(8), .STORE_SECT_W(2),
                     .LOAD_WINDOW(W), .PROG_CYCLES(P)) i_sector_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy));

  always #10 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_mem [int];
  logic [7:0] m_buf [int];
  int   m_state = 0, m_cnt = 0, m_sec = 0;
  logic [7:0] m_last = 0;
  logic m_tgl = 0;
  logic [7:0] exp_dout = 0;
  logic exp_busy = 0;
  string m_tag = "R9";

  function automatic int key_of(int a);
    return (((a >> 8) % 4) * 256) + (a & 255);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem.delete(); m_buf.delete();
      m_state = 0; m_cnt = 0; m_sec = 0; m_last = 0; m_tgl = 0;
      exp_dout = 0; exp_busy = 0; m_tag = "R9";
    end else begin
      automatic bit rd = !ce_n && !oe_n && we_n;
      automatic bit wr = !ce_n && !we_n && oe_n;
      automatic int a = int'(addr);
      if (rd && m_state == 2) begin
        exp_dout = {~m_last[7], m_tgl, m_last[5:0]};
        m_tgl = !m_tgl; m_tag = "R5";
      end else if (rd) begin
        exp_dout = m_mem.exists(key_of(a)) ? m_mem[key_of(a)] : 8'hFF;
        m_tag = "R1";
      end else begin
        exp_dout = 0; m_tag = "R1";
      end
      if (m_state == 0) begin
        if (wr) begin
          m_state = 1; m_cnt = 0; m_sec = a >> 8;
          m_buf[a & 255] = din; m_last = din;
        end
      end else if (m_state == 1) begin
        if (wr && (a >> 8) == m_sec) begin
          m_cnt = 0; m_buf[a & 255] = din; m_last = din;
        end else if (m_cnt == W - 1) begin
          m_state = 2; m_cnt = 0; m_tgl = 0;
        end else m_cnt++;
      end else begin
        if (m_cnt == P - 1) begin
          for (int b = 0; b < 256; b++)
            m_mem[(m_sec % 4) * 256 + b] = m_buf.exists(b) ? m_buf[b] : 8'hFF;
          m_buf.delete(); m_state = 0; m_cnt = 0;
        end else m_cnt++;
      end
      exp_busy = (m_state == 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (dout !== exp_dout) begin
        failures++;
        $display("FAIL %s model dout actual=%h expected=%h at %0t", m_tag, dout, exp_dout, $time);
      end
      checks++;
      if (busy !== exp_busy) begin
        failures++;
        $display("FAIL R3 R4 model busy actual=%b expected=%b at %0t", busy, exp_busy, $time);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nop();
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
  endtask

  task automatic raw(logic c, logic o, logic w, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); ce_n = c; oe_n = o; we_n = w; addr = a; din = d;
  endtask

  task automatic rd(logic [AW-1:0] a);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
  endtask

  task automatic rdchk(logic [AW-1:0] a, logic [7:0] exp, string tag);
    rd(a); nop(); chk(tag, dout, exp);
  endtask

  task automatic wait_busy(string tag);
    for (int j = 1; j <= W + 1; j++) begin
      nop(); chk(tag, {7'd0, busy}, {7'd0, j == W + 1});
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 busy after reset", {7'd0, busy}, 8'h00);
    chk("R9 dout after reset", dout, 8'h00);
    rdchk(18'h00105, 8'hFF, "R9 blank array");

    // phase A: load sector 1 out of order, window restart, foreign sector
    wr(18'h00110, 8'hA5);
    repeat (10) nop();
    wr(18'h00205, 8'h11);            // R8 other sector ignored
    repeat (7) nop();
    wr(18'h00103, 8'h3C);            // R3 restart one cycle before close
    wr(18'h001FF, 8'h81);
    wait_busy("R3 window close");
    rd(18'h001FF);
    rd(18'h001FF);
    chk("R5 poll status", dout, 8'h01);
    nop();
    chk("R6 toggle second read", dout, 8'h41);
    rd(18'h00000); nop();
    chk("R6 toggle third read", dout, 8'h01);
    wr(18'h00110, 8'h00);            // R7 write while busy
    for (int n = 0; n < P + 5 && busy; n++) nop();
    chk("R4 busy cleared", {7'd0, busy}, 8'h00);
    rdchk(18'h00110, 8'hA5, "R7 busy write ignored");
    rdchk(18'h00103, 8'h3C, "R4 loaded byte");
    rdchk(18'h001FF, 8'h81, "R2 loaded byte");
    rdchk(18'h00100, 8'hFF, "R4 unloaded byte");
    rdchk(18'h00205, 8'hFF, "R8 other sector untouched");
    rdchk(18'h00510, 8'hA5, "R1 sector alias");

    // phase B: rejected strobes, single byte reload, cycle length
    raw(1, 1, 0, 18'h00110, 8'h55);
    raw(0, 0, 0, 18'h00110, 8'h55);
    for (int j = 0; j < W + 2; j++) begin
      nop(); chk("R2 rejected strobe", {7'd0, busy}, 8'h00);
    end
    wr(18'h00110, 8'h7E);
    wait_busy("R3 window close B");
    begin
      int n;
      n = 0;
      for (int k = 0; k < P + 5; k++) begin
        nop();
        if (!busy) break;
        n++;
      end
      chk("R4 cycle length", 8'(n), 8'(P - 1));
    end
    rdchk(18'h00110, 8'h7E, "R4 reloaded byte");
    rdchk(18'h00103, 8'hFF, "R4 byte not reloaded");
    rdchk(18'h00510, 8'h7E, "R1 alias after reload");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule